// File: doc/BRIEF.md
# Oscilloscope Trigger Detection Unit

This block decides when an acquisition is triggered. It watches one analog channel, picked from a bus of simultaneously sampled 14-bit signed channels, and a bank of asynchronous digital trigger lines. It can also fire on a software strobe or on every re-arm. When the selected condition is met while the unit is armed, it emits a single-cycle pulse together with the running index of the sample that caused it. The analog detector has three variants. Edge mode fires on a level crossing. Window mode fires on entering or leaving a band. Hysteresis mode fires on an edge only after the signal has first moved past the level by a set margin in the opposite direction.

After every pulse the unit stays blind for a blocking interval. The interval always covers a fixed dead-time floor and stretches to a programmable holdoff held in a 64-bit counter. Digital lines pass through a two-flop synchroniser and are then resolved at half the sample rate. The configuration inputs are plain static levels, written by the surrounding register logic.

The controller has four states:
- `ST_IDLE`: disabled.
- `ST_ARMED`: watching the selected source.
- `ST_DEAD`: counting the dead-time floor.
- `ST_HOLD`: counting the holdoff beyond that floor.

Its transitions are:
- enable (IDLE to ARMED)
- fire (ARMED to DEAD)
- floor_done_rearm (DEAD to ARMED, when the holdoff does not exceed the floor)
- floor_done_hold (DEAD to HOLD)
- holdoff_done (HOLD to ARMED)
- disable (any state to IDLE)

Top module: `trig_detect_unit`

## Requirements
- R1: After reset, `trig_pulse` is 0 and `trig_index` is 0, and no pulse appears until the unit is enabled.
- R2: Mode code 0 (edge) fires on a valid sample when the previous valid sample of the selected channel is below `cfg_level` and the current one is at or above it (`cfg_slope`=0). With `cfg_slope`=1 it fires when the previous sample is at or above the level and the current one is below it.
- R3: Mode code 1 (window) treats a sample as inside when `cfg_low` <= sample <= `cfg_high`. It fires on an outside-to-inside move when `cfg_win_exit`=0, and on an inside-to-outside move when `cfg_win_exit`=1.
- R4: Mode code 2 (hysteresis) fires on the R2 edge only once armed. For a rising slope, arming needs an earlier valid sample at or below `cfg_level`-`cfg_hyst`. For a falling slope, it needs an earlier valid sample at or above `cfg_level`+`cfg_hyst`. Each crossing, and each disable, clears the arming.
- R5: Mode code 3 (digital) watches line `cfg_dsel` (0 to 14) of `dig_lines`, after synchronisation and sampling on every second clock. It fires on a rising change (`cfg_slope`=0) or a falling change (`cfg_slope`=1). A level held for two clocks is always seen, exactly once. Other lines, and select values of 15, never fire.
- R6: Mode code 5 (software) fires in the cycle `sw_strobe` is sampled high. The strobe has no effect in the other modes.
- R7: Mode code 4 (immediate) fires on the first clock the unit is armed.
- R8: After a pulse, no pulse occurs for B = max(DEAD_MIN, `cfg_holdoff`) clocks, with DEAD_MIN = 130. In immediate mode, successive pulses are exactly B+1 clocks apart. The holdoff is a full 64-bit count.
- R9: `trig_pulse` lasts one clock. `trig_index` holds the number of valid samples accepted before the clock that fired. Samples with `smp_valid`=0 neither count nor take part in analog detection.
- R10: While `cfg_enable` is 0 no pulse is produced. Raising it re-arms the unit on the next clock.
- R11: Only channel `cfg_ach_sel` of `smp_bus` (channel c at bits c*14 and up) affects analog detection.
- R12: Mode codes 6 and 7 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Arms the unit when high |
| cfg_mode | input | 3 | Detection mode code |
| cfg_slope | input | 1 | 0 rising, 1 falling |
| cfg_win_exit | input | 1 | Window: 0 fire on entry, 1 fire on exit |
| cfg_ach_sel | input | 3 | Analog channel select |
| cfg_dsel | input | 4 | Digital line select |
| cfg_level | input | 14 | Signed trigger level |
| cfg_low | input | 14 | Signed window lower bound |
| cfg_high | input | 14 | Signed window upper bound |
| cfg_hyst | input | 14 | Unsigned hysteresis margin |
| cfg_holdoff | input | 64 | Holdoff length in clocks |
| smp_valid | input | 1 | Sample bus carries a new sample |
| smp_bus | input | 112 | Eight packed signed 14-bit channels |
| dig_lines | input | 15 | Asynchronous digital trigger lines |
| sw_strobe | input | 1 | Software trigger request |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_index | output | 32 | Index of the triggering sample |

## Verification
If the armed flag or the stored previous sample goes wrong, the fault shows on `trig_pulse` at the very next valid sample, as a missing or extra pulse in the sweeps over level, sample pairs and slope. If the blocking counter or the dead and hold state goes wrong, immediate mode shows it within one blocking interval, as a pulse spacing other than B+1. If the half-rate digital sampler or the synchroniser goes wrong, a two-clock pulse fires twice or not at all, within about six clocks. An index fault appears as an off-by-n `trig_index` on the first pulse after it.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam logic [2:0] MODE_EDGE    = 3'd0;
    localparam logic [2:0] MODE_WINDOW  = 3'd1;
    localparam logic [2:0] MODE_HYST    = 3'd2;
    localparam logic [2:0] MODE_DIGITAL = 3'd3;
    localparam logic [2:0] MODE_IMMED   = 3'd4;
    localparam logic [2:0] MODE_SOFT    = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DEAD  = 2'd2,
        ST_HOLD  = 2'd3
    } tstate_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic [1:0] stg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= 2'b00;
                else        stg <= {stg[0], d_async[gi]};
            end
            assign q_sync[gi] = stg[1];
        end
    endgenerate
endmodule

// File: rtl/trig_digital.sv
module trig_digital #(
    parameter int N_LINES = 15,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_s,
    input  logic [SEL_W-1:0]   sel,
    input  logic               falling,
    output logic               hit
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] padded;
    logic            sel_ok;
    logic            cur;
    logic            phase;
    logic            half_q;
    logic            half_ok;

    always_comb begin
        padded = '0;
        padded[N_LINES-1:0] = lines_s;
    end

    assign sel_ok = (int'(sel) < N_LINES);
    assign cur    = padded[sel];

    // Sampling every second clock gives the two-period digital resolution.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= 1'b0;
            half_q  <= 1'b0;
            half_ok <= 1'b0;
            hit     <= 1'b0;
        end else begin
            phase <= ~phase;
            hit   <= 1'b0;
            if (phase) begin
                half_q  <= cur;
                half_ok <= 1'b1;
                hit     <= sel_ok && half_ok &&
                           (falling ? (half_q && !cur) : (!half_q && cur));
            end
        end
    end

    assert_half_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit)
        else $error("digital hit on two adjacent clocks");
endmodule

// File: rtl/trig_analog.sv
module trig_analog
    import trig_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    valid,
    input  logic signed [SMP_W-1:0] sample,
    input  logic [2:0]              mode,
    input  logic                    falling,
    input  logic                    win_exit,
    input  logic signed [SMP_W-1:0] level,
    input  logic signed [SMP_W-1:0] low,
    input  logic signed [SMP_W-1:0] high,
    input  logic [SMP_W-1:0]        hyst,
    output logic                    hit
);
    localparam int XW = SMP_W + 2;

    logic signed [XW-1:0] cur_x, prev_x, lvl_x, lo_x, hi_x, hys_x;
    logic signed [SMP_W-1:0] prev_q;
    logic prev_ok;
    logic hy_arm;
    logic edge_hit, win_hit, pass_arm, in_prev, in_cur;

    assign cur_x  = XW'(sample);
    assign prev_x = XW'(prev_q);
    assign lvl_x  = XW'(level);
    assign lo_x   = XW'(low);
    assign hi_x   = XW'(high);
    assign hys_x  = $signed({2'b00, hyst});

    always_comb begin
        edge_hit = falling ? (prev_x >= lvl_x && cur_x < lvl_x)
                           : (prev_x < lvl_x && cur_x >= lvl_x);
        in_prev  = (prev_x >= lo_x) && (prev_x <= hi_x);
        in_cur   = (cur_x >= lo_x) && (cur_x <= hi_x);
        win_hit  = win_exit ? (in_prev && !in_cur) : (!in_prev && in_cur);
        pass_arm = falling ? (cur_x >= lvl_x + hys_x) : (cur_x <= lvl_x - hys_x);
        hit = 1'b0;
        if (valid && prev_ok) begin
            case (mode)
                MODE_EDGE:   hit = edge_hit;
                MODE_WINDOW: hit = win_hit;
                MODE_HYST:   hit = hy_arm && edge_hit;
                default:     hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            prev_ok <= 1'b0;
        end else if (valid) begin
            prev_q  <= sample;
            prev_ok <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     hy_arm <= 1'b0;
        else if (!en)                                   hy_arm <= 1'b0;
        else if (valid && prev_ok && hy_arm && edge_hit) hy_arm <= 1'b0;
        else if (valid && pass_arm)                     hy_arm <= 1'b1;
    end

    assert_arm_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hy_arm) |-> $past(en) && $past(valid))
        else $error("hysteresis armed without an enabled valid sample");
endmodule

// File: rtl/trig_detect_unit.sv
module trig_detect_unit
    import trig_pkg::*;
#(
    parameter int SMP_W    = 14,
    parameter int N_ACH    = 8,
    parameter int N_DIG    = 15,
    parameter int IDX_W    = 32,
    parameter int HOLD_W   = 64,
    parameter int DEAD_MIN = 130,
    localparam int ASEL_W  = $clog2(N_ACH),
    localparam int DSEL_W  = $clog2(N_DIG + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_enable,
    input  logic [2:0]                cfg_mode,
    input  logic                      cfg_slope,
    input  logic                      cfg_win_exit,
    input  logic [ASEL_W-1:0]         cfg_ach_sel,
    input  logic [DSEL_W-1:0]         cfg_dsel,
    input  logic signed [SMP_W-1:0]   cfg_level,
    input  logic signed [SMP_W-1:0]   cfg_low,
    input  logic signed [SMP_W-1:0]   cfg_high,
    input  logic [SMP_W-1:0]          cfg_hyst,
    input  logic [HOLD_W-1:0]         cfg_holdoff,
    input  logic                      smp_valid,
    input  logic [N_ACH*SMP_W-1:0]    smp_bus,
    input  logic [N_DIG-1:0]          dig_lines,
    input  logic                      sw_strobe,
    output logic                      trig_pulse,
    output logic [IDX_W-1:0]          trig_index
);
    localparam int ASPAN = 1 << ASEL_W;
    localparam logic [HOLD_W-1:0] FLOOR_LAST = HOLD_W'(DEAD_MIN - 1);
    localparam logic [HOLD_W-1:0] FLOOR_LEN  = HOLD_W'(DEAD_MIN);

    logic signed [SMP_W-1:0] ch_arr [ASPAN];
    logic [N_DIG-1:0] dig_s;
    logic an_hit, dg_hit, src_hit, fire;
    logic [HOLD_W-1:0] blk_cnt;
    logic [IDX_W-1:0]  smp_count;
    tstate_e state, state_nx;

    genvar gc;
    generate
        for (gc = 0; gc < ASPAN; gc++) begin : g_ch
            if (gc < N_ACH) begin : g_real
                assign ch_arr[gc] = smp_bus[gc*SMP_W +: SMP_W];
            end else begin : g_pad
                assign ch_arr[gc] = '0;
            end
        end
    endgenerate

    trig_sync #(.W(N_DIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(dig_lines), .q_sync(dig_s)
    );

    trig_digital #(.N_LINES(N_DIG), .SEL_W(DSEL_W)) u_dig (
        .clk(clk), .rst_n(rst_n), .lines_s(dig_s), .sel(cfg_dsel),
        .falling(cfg_slope), .hit(dg_hit)
    );

    trig_analog #(.SMP_W(SMP_W)) u_ana (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .valid(smp_valid),
        .sample(ch_arr[cfg_ach_sel]), .mode(cfg_mode), .falling(cfg_slope),
        .win_exit(cfg_win_exit), .level(cfg_level), .low(cfg_low),
        .high(cfg_high), .hyst(cfg_hyst), .hit(an_hit)
    );

    always_comb begin
        case (cfg_mode)
            MODE_EDGE, MODE_WINDOW, MODE_HYST: src_hit = an_hit;
            MODE_DIGITAL:                      src_hit = dg_hit;
            MODE_IMMED:                        src_hit = 1'b1;
            MODE_SOFT:                         src_hit = sw_strobe;
            default:                           src_hit = 1'b0;
        endcase
    end

    assign fire = (state == ST_ARMED) && cfg_enable && src_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cfg_enable) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (!cfg_enable) state_nx = ST_IDLE;
                else if (fire)   state_nx = ST_DEAD;
            end
            ST_DEAD: begin
                if (!cfg_enable) state_nx = ST_IDLE;
                else if (blk_cnt == FLOOR_LAST)
                    state_nx = (cfg_holdoff > FLOOR_LEN) ? ST_HOLD : ST_ARMED;
            end
            ST_HOLD: begin
                if (!cfg_enable) state_nx = ST_IDLE;
                else if (blk_cnt >= cfg_holdoff - 1'b1) state_nx = ST_ARMED;
            end
        endcase
    end

    // State register and blocking counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            blk_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DEAD || state == ST_HOLD) blk_cnt <= blk_cnt + 1'b1;
            else                                      blk_cnt <= '0;
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            trig_index <= '0;
            smp_count  <= '0;
        end else begin
            trig_pulse <= fire;
            if (fire)      trig_index <= smp_count;
            if (smp_valid) smp_count  <= smp_count + 1'b1;
        end
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse)
        else $error("trigger pulse wider than one clock");

    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !trig_pulse)
        else $error("pulse produced while disabled");

    assert_armed_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(state) == ST_ARMED)
        else $error("pulse not issued from the armed state");

    assert_hold_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> blk_cnt >= FLOOR_LEN)
        else $error("holdoff entered before dead-time floor elapsed");
endmodule

// File: tb/trig_detect_unit_tb_top.sv
`timescale 1ns/1ps
module trig_detect_unit_tb_top;
    localparam int W = 14;
    localparam int NCH = 8;
    localparam int ND = 15;
    localparam int DMIN = 130;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [2:0] mode = 3'd0;
    logic slope = 1'b0, wexit = 1'b0;
    logic [2:0] asel = 3'd0;
    logic [3:0] dsel = 4'd0;
    logic signed [W-1:0] lvl = '0, lo = '0, hi = '0;
    logic [W-1:0] hys = '0;
    logic [63:0] hold = '0;
    logic valid = 1'b0;
    logic [NCH*W-1:0] bus = '0;
    logic [ND-1:0] dig = '0;
    logic sw = 1'b0;
    logic pulse;
    logic [31:0] index;

    logic [NCH*W-1:0] nx_bus = '0;
    logic [ND-1:0] nx_dig = '0;
    logic nx_sw = 1'b0;
    int n_chk = 0, n_fail = 0, n_valid = 0;
    logic got_p;
    logic [31:0] got_i;

    always #4 clk = ~clk;

    trig_detect_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_mode(mode),
        .cfg_slope(slope), .cfg_win_exit(wexit), .cfg_ach_sel(asel),
        .cfg_dsel(dsel), .cfg_level(lvl), .cfg_low(lo), .cfg_high(hi),
        .cfg_hyst(hys), .cfg_holdoff(hold), .smp_valid(valid),
        .smp_bus(bus), .dig_lines(dig), .sw_strobe(sw),
        .trig_pulse(pulse), .trig_index(index)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int v);
        for (int c = 0; c < NCH; c++) nx_bus[c*W +: W] = W'(v);
    endtask

    task automatic push(input logic v);
        @(negedge clk);
        bus = nx_bus; dig = nx_dig; sw = nx_sw; valid = v;
        @(posedge clk);
        #2;
        got_p = pulse;
        got_i = index;
        if (v) n_valid++;
    endtask

    // Disable for one sample of value a, then enable on a second one.
    task automatic rearm(input int a);
        en = 1'b0; fill(a); push(1'b1);
        en = 1'b1; push(1'b1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        summary();
        $finish;
    end

    initial begin
        int vals[9] = '{-8192, -100, -1, 0, 1, 99, 100, 101, 8191};
        int lvls[3] = '{-1, 0, 100};
        int wv[7]   = '{-11, -10, -9, 0, 9, 10, 11};
        longint holds[4] = '{0, 130, 131, 200};
        int exp_i;
        bit e;

        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 pulse", pulse, 0);
        chk("R1 index", index, 0);
        rst_n = 1'b1;
        mode = 3'd4;
        repeat (5) push(1'b1);
        chk("R1 no pulse before enable", got_p, 0);

        // R2 edge sweep
        mode = 3'd0;
        for (int li = 0; li < 3; li++)
            for (int s = 0; s < 2; s++)
                for (int ai = 0; ai < 9; ai++)
                    for (int bi = 0; bi < 9; bi++) begin
                        lvl = W'(lvls[li]); slope = s[0];
                        rearm(vals[ai]);
                        fill(vals[bi]); exp_i = n_valid; push(1'b1);
                        e = s ? (vals[ai] >= lvls[li] && vals[bi] < lvls[li])
                              : (vals[ai] < lvls[li] && vals[bi] >= lvls[li]);
                        chk("R2 edge", got_p, e);
                        if (e) chk("R9 index", got_i, exp_i);
                    end

        // R3 window sweep
        mode = 3'd1;
        for (int p = 0; p < 2; p++)
            for (int x = 0; x < 2; x++)
                for (int ai = 0; ai < 7; ai++)
                    for (int bi = 0; bi < 7; bi++) begin
                        bit ia, ib;
                        lo = W'(p ? 0 : -10); hi = W'(p ? 0 : 10); wexit = x[0];
                        rearm(wv[ai]);
                        fill(wv[bi]); push(1'b1);
                        ia = (wv[ai] >= int'(lo)) && (wv[ai] <= int'(hi));
                        ib = (wv[bi] >= int'(lo)) && (wv[bi] <= int'(hi));
                        e = x ? (ia && !ib) : (!ia && ib);
                        chk("R3 window", got_p, e);
                    end

        // R4 hysteresis sweeps
        mode = 3'd2; lvl = '0; hys = W'(20);
        for (int a = -30; a <= -10; a++) begin
            slope = 1'b0;
            rearm(0);
            fill(a); push(1'b1);
            fill(-1); push(1'b1);
            chk("R4 rise quiet", got_p, 0);
            fill(0); push(1'b1);
            chk("R4 rise", got_p, a <= -20);
        end
        for (int a = 10; a <= 30; a++) begin
            slope = 1'b1;
            rearm(0);
            fill(a); push(1'b1);
            fill(1); push(1'b1);
            fill(-1); push(1'b1);
            chk("R4 fall", got_p, a >= 20);
        end

        // R11 channel select
        mode = 3'd0; slope = 1'b0; lvl = '0;
        for (int c = 0; c < NCH; c++) begin
            asel = 3'(c);
            rearm(-50);
            fill(50); nx_bus[c*W +: W] = W'(-50); push(1'b1);
            chk("R11 other channels ignored", got_p, 0);
            fill(50); push(1'b1);
            chk("R11 selected channel", got_p, 1);
        end
        asel = '0;

        // R9 invalid samples
        rearm(-5);
        fill(5); push(1'b0);
        chk("R9 invalid ignored", got_p, 0);
        exp_i = n_valid; push(1'b1);
        chk("R9 valid fires", got_p, 1);
        chk("R9 index after gap", got_i, exp_i);
        push(1'b1);
        chk("R9 one clock wide", got_p, 0);

        // R5 digital lines
        mode = 3'd4 - 3'd1;
        fill(0);
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 16; d++) begin
                logic [ND-1:0] idle, mask;
                int cnt;
                idle = s ? '1 : '0;
                mask = (d < ND) ? ND'(1 << d) : '0;
                slope = s[0]; dsel = 4'(d);
                nx_dig = idle; en = 1'b0;
                repeat (4) push(1'b1);
                en = 1'b1;
                repeat (4) push(1'b1);
                cnt = 0;
                nx_dig = idle ^ ~mask; push(1'b1); cnt += got_p;
                push(1'b1); cnt += got_p;
                nx_dig = idle;
                repeat (8) begin push(1'b1); cnt += got_p; end
                chk("R5 unselected lines", cnt, 0);
                cnt = 0;
                nx_dig = idle ^ mask; push(1'b1); cnt += got_p;
                push(1'b1); cnt += got_p;
                nx_dig = idle;
                repeat (8) begin push(1'b1); cnt += got_p; end
                chk("R5 selected line pulse", cnt, (d < ND) ? 1 : 0);
            end
        nx_dig = '0; dsel = '0; slope = 1'b0;

        // R6 software strobe
        mode = 3'd5;
        rearm(0);
        nx_sw = 1'b1; exp_i = n_valid; push(1'b1); nx_sw = 1'b0;
        chk("R6 strobe fires", got_p, 1);
        chk("R6 index", got_i, exp_i);
        mode = 3'd0; lvl = W'(100);
        rearm(0);
        nx_sw = 1'b1; push(1'b1); nx_sw = 1'b0;
        chk("R6 strobe ignored in edge mode", got_p, 0);

        // R12 reserved codes
        for (int m = 6; m < 8; m++) begin
            int cnt;
            mode = 3'(m); rearm(0); cnt = 0;
            nx_sw = 1'b1;
            repeat (10) begin push(1'b1); cnt += got_p; end
            nx_sw = 1'b0;
            chk("R12 reserved mode silent", cnt, 0);
        end

        // R7 / R8 immediate spacing
        mode = 3'd4;
        for (int h = 0; h < 4; h++) begin
            longint b;
            int first, second, cnt;
            hold = 64'(holds[h]);
            b = (holds[h] > DMIN) ? holds[h] : DMIN;
            en = 1'b0; push(1'b1); en = 1'b1;
            first = -1; second = -1; cnt = 0;
            for (int k = 0; k < 2*b + 3; k++) begin
                push(1'b1);
                if (got_p) begin
                    cnt++;
                    if (first < 0) first = k; else if (second < 0) second = k;
                end
            end
            chk("R7 first pulse on arming", first, 1);
            chk("R8 spacing", second - first, b + 1);
            chk("R8 pulse count", cnt, 2);
        end
        hold = 64'hFFFF_FFFF_FFFF_FFFF;
        begin
            int cnt;
            en = 1'b0; push(1'b1); en = 1'b1; cnt = 0;
            repeat (600) begin push(1'b1); cnt += got_p; end
            chk("R8 wide holdoff", cnt, 1);
        end
        hold = '0;

        // R10 disabled
        begin
            int cnt;
            en = 1'b0; cnt = 0;
            repeat (20) begin push(1'b1); cnt += got_p; end
            chk("R10 disabled silent", cnt, 0);
            en = 1'b1; push(1'b1);
            chk("R10 arming clock quiet", got_p, 0);
            push(1'b1);
            chk("R10 re-armed", got_p, 1);
        end

        summary();
        $finish;
    end
endmodule